// File: doc/BRIEF.md
# I2C Master Byte Engine with Status Codes

This block is a byte-at-a-time I2C master controlled through four 8-bit registers. Software asks for a START, writes an address or data byte, or asks for a read. The engine runs one bus event at a time. When the event finishes, it raises an event flag, loads an 8-bit code that says what happened, and holds SCL low. It does nothing more until software writes the control register with the flag bit clear. Every decision sits with software: whether to send another byte, whether to ACK a received byte, and whether to follow with a repeated START or a STOP.

Both 7-bit and 10-bit addressing are handled. A first address byte whose upper five bits are `11110` marks a 10-bit address. The engine then treats the next byte written as the second address byte and reports it with its own codes. Bus timing comes from an external prescaler: each `tick_i` pulse advances one quarter of an SCL period. SCL and SDA are open-drain lines, so each one is driven low or released and never driven high.

Top module: `i2c_status_master`

## Requirements
- R1: Register offsets are: 0 data, 1 control, 2 status (read only), 3 soft reset (write only). After reset, status reads 0xF8, control and data read 0x00, `irq_o` is low and both lines are released.
- R2: A START requested (control bit 5) while the bus is free produces a START condition and then parks with status 0x08. A START requested while the engine holds the bus produces a repeated START and status 0x10. The START bit clears itself.
- R3: The first byte written after a START is sent MSB first as the address. Bit 0 of that byte is R/W, with 1 meaning read. A slave ACK gives 0x18 for write and 0x40 for read. A NACK gives 0x20 for write and 0x48 for read.
- R4: On the write path, each later byte is shifted out MSB first. ACK gives 0x28 and NACK gives 0x30.
- R5: On the read path, releasing the flag clocks in 8 bits MSB first, and the byte can then be read from the data register. If control bit 2 (ACK) is set, the master pulls SDA low in the ninth bit and the status is 0x50. Otherwise the master leaves SDA released and the status is 0x58.
- R6: An address byte of the form 11110xxR is followed by a second address byte. Its status is 0xD0 (ACK) or 0xD8 (NACK) when R=0, and 0xE0 (ACK) or 0xE8 (NACK) when R=1. After an ACKed second byte, transfers continue on the write or read path as R selects.
- R7: While the event flag (control bit 3) is set and arbitration has not been lost, SCL is held low and no action starts. Writing control with bit 3 = 0 clears the flag and starts the next action. Writing control with bit 3 = 1 leaves the flag set.
- R8: `irq_o` is high exactly when the flag is set and the interrupt enable (control bit 7) is set.
- R9: A STOP request (control bit 4), acted on when the flag is released, drives a STOP condition. It then leaves both lines released and the STOP bit clear, and it sets status to 0xF8 without raising the flag.
- R10: If the master releases SDA to send a 1 and samples SDA low, it abandons the byte. It sets status 0x38 and the flag, and releases both lines. A later START counts as a fresh START (0x08).
- R11: While the enable bit (control bit 6) is clear, requests are ignored: no bus activity, the flag stays clear, status is unchanged, and both lines are released.
- R12: Any write to offset 3 returns control, status and data to their reset values and releases the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Quarter-SCL-period strobe from the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt: flag AND interrupt enable |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench runs a bit-accurate slave model on the wired-AND lines and walks the status sequence over several kinds of traffic:
- a 7-bit write with ACKed and NACKed data;
- a 7-bit read that returns ACK and then NACK;
- repeated STARTs whose addresses are NACKed in both directions;
- 10-bit transfers covering all four second-address codes.

The address patterns tell the read and write paths apart and the 7-bit and 10-bit paths apart. The bench also checks the byte the slave captured and the ACK level the master returned, which shows the bit order and the ACK-bit handling. A slave that pulls SDA low during a 1 bit tells arbitration loss apart from an ordinary NACK. Runs with the interrupt enable clear, with the engine disabled, and with a soft reset in the middle of a transfer show the side conditions.

// File: rtl/i2c_sm_pkg.sv
package i2c_sm_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} cmd_e;
  typedef enum logic [1:0] {NX_ADDR, NX_ADDR2, NX_TX, NX_RX} next_e;

  localparam logic [REG_DW-1:0] ST_START   = 8'h08;
  localparam logic [REG_DW-1:0] ST_RSTART  = 8'h10;
  localparam logic [REG_DW-1:0] ST_WA_ACK  = 8'h18;
  localparam logic [REG_DW-1:0] ST_WA_NAK  = 8'h20;
  localparam logic [REG_DW-1:0] ST_WD_ACK  = 8'h28;
  localparam logic [REG_DW-1:0] ST_WD_NAK  = 8'h30;
  localparam logic [REG_DW-1:0] ST_ARB     = 8'h38;
  localparam logic [REG_DW-1:0] ST_RA_ACK  = 8'h40;
  localparam logic [REG_DW-1:0] ST_RA_NAK  = 8'h48;
  localparam logic [REG_DW-1:0] ST_RD_ACK  = 8'h50;
  localparam logic [REG_DW-1:0] ST_RD_NAK  = 8'h58;
  localparam logic [REG_DW-1:0] ST_W2_ACK  = 8'hD0;
  localparam logic [REG_DW-1:0] ST_W2_NAK  = 8'hD8;
  localparam logic [REG_DW-1:0] ST_R2_ACK  = 8'hE0;
  localparam logic [REG_DW-1:0] ST_R2_NAK  = 8'hE8;
  localparam logic [REG_DW-1:0] ST_NONE    = 8'hF8;

  // control register bit positions (software decodes these)
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [REG_AW-1:0] RA_DATA = 2'd0;
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
  localparam logic [REG_AW-1:0] RA_SRST = 2'd3;

  localparam logic [4:0] TEN_MARK = 5'b11110;
endpackage

// File: rtl/i2c_sm_bit_eng.sv
module i2c_sm_bit_eng
  import i2c_sm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  cmd_e              cmd_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              ack_out_i,
  input  logic              sda_i,
  output logic              done_o,
  output logic              arb_lost_o,
  output logic              ack_seen_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              idle_o,
  output logic              bus_held_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_e;

  st_e               st_q;
  logic [1:0]        q_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rd_q, ackd_q, held_q;

  wire ack_slot = (bit_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; q_q <= '0; bit_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; ackd_q <= 1'b0; held_q <= 1'b0;
      done_o <= 1'b0; arb_lost_o <= 1'b0; ack_seen_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        st_q <= S_IDLE; held_q <= 1'b0; arb_lost_o <= 1'b0;
      end else if (st_q == S_IDLE) begin
        if (cmd_valid_i) begin
          q_q <= '0; bit_q <= '0; arb_lost_o <= 1'b0;
          rd_q <= (cmd_i == CMD_READ);
          ackd_q <= ack_out_i;
          if (cmd_i == CMD_WRITE) sh_q <= tx_byte_i;
          unique case (cmd_i)
            CMD_START: st_q <= S_START;
            CMD_STOP:  st_q <= S_STOP;
            default:   st_q <= S_BITS;
          endcase
        end
      end else if (tick_i) begin
        q_q <= q_q + 2'd1;
        if (q_q == 2'd2 && st_q == S_BITS) begin
          if (ack_slot) begin
            if (!rd_q) ack_seen_o <= !sda_i;
          end else if (rd_q) begin
            sh_q <= {sh_q[BYTE_W-2:0], sda_i};
          end else if (sh_q[BYTE_W-1] && !sda_i) begin
            // another master owns the line: give up the byte and the bus
            st_q <= S_IDLE; held_q <= 1'b0; arb_lost_o <= 1'b1; done_o <= 1'b1;
          end
        end
        if (q_q == 2'd3) begin
          unique case (st_q)
            S_START: begin st_q <= S_IDLE; held_q <= 1'b1; done_o <= 1'b1; end
            S_STOP:  begin st_q <= S_IDLE; held_q <= 1'b0; done_o <= 1'b1; end
            S_BITS: begin
              if (ack_slot) begin
                st_q <= S_IDLE; done_o <= 1'b1;
              end else begin
                bit_q <= bit_q + CNT_W'(1);
                if (!rd_q) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // quarter 0 and 3 of a bit have SCL low, 1 and 2 high
  always_comb begin
    scl_low_o = 1'b0;
    sda_low_o = 1'b0;
    unique case (st_q)
      S_IDLE:  scl_low_o = held_q;
      S_START: begin
        scl_low_o = (q_q == 2'd0) ? held_q : (q_q == 2'd3);
        sda_low_o = (q_q >= 2'd2);
      end
      S_BITS: begin
        scl_low_o = (q_q == 2'd0) || (q_q == 2'd3);
        sda_low_o = ack_slot ? (rd_q && ackd_q) : (!rd_q && !sh_q[BYTE_W-1]);
      end
      S_STOP: begin
        scl_low_o = (q_q == 2'd0);
        sda_low_o = (q_q <= 2'd1);
      end
      default: ;
    endcase
  end

  assign rx_byte_o  = sh_q;
  assign idle_o     = (st_q == S_IDLE);
  assign bus_held_o = held_q;
endmodule

// File: rtl/i2c_sm_ctrl.sv
module i2c_sm_ctrl
  import i2c_sm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o,
  input  logic              eng_idle_i,
  input  logic              bus_held_i,
  input  logic              done_i,
  input  logic              arb_lost_i,
  input  logic              ack_seen_i,
  input  logic [REG_DW-1:0] rx_byte_i,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [REG_DW-1:0] tx_byte_o,
  output logic              ack_out_o,
  output logic              clr_o,
  output logic              flag_o,
  output logic [REG_DW-1:0] status_o,
  output logic              en_o
);
  logic en_q, ien_q, ack_q, sta_q, sto_q, flag_q, pend_q, rep_q, rw_q, acki_q;
  logic [REG_DW-1:0] data_q, stat_q, lat_q;
  next_e nx_q;
  cmd_e  cur_q;

  wire srst   = we_i && (addr_i == RA_SRST);
  wire can_go = en_q && !flag_q && !pend_q && eng_idle_i;

  assign clr_o = srst || !en_q;

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_o       = CMD_WRITE;
    if (can_go) begin
      if (sto_q && bus_held_i) begin
        cmd_valid_o = 1'b1; cmd_o = CMD_STOP;
      end else if (!sto_q && sta_q) begin
        cmd_valid_o = 1'b1; cmd_o = CMD_START;
      end else if (!sto_q && bus_held_i) begin
        cmd_valid_o = 1'b1;
        cmd_o = (nx_q == NX_RX) ? CMD_READ : CMD_WRITE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ien_q <= 1'b0; ack_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      flag_q <= 1'b0; pend_q <= 1'b0; rep_q <= 1'b0; rw_q <= 1'b0; acki_q <= 1'b0;
      data_q <= '0; stat_q <= ST_NONE; lat_q <= '0; nx_q <= NX_ADDR; cur_q <= CMD_START;
    end else if (srst) begin
      en_q <= 1'b0; ien_q <= 1'b0; ack_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      flag_q <= 1'b0; pend_q <= 1'b0; rep_q <= 1'b0; rw_q <= 1'b0; acki_q <= 1'b0;
      data_q <= '0; stat_q <= ST_NONE; lat_q <= '0; nx_q <= NX_ADDR; cur_q <= CMD_START;
    end else begin
      if (we_i && addr_i == RA_DATA) data_q <= wdata_i;
      if (we_i && addr_i == RA_CTRL) begin
        ien_q  <= wdata_i[CB_IEN];
        en_q   <= wdata_i[CB_EN];
        sta_q  <= wdata_i[CB_START];
        sto_q  <= wdata_i[CB_STOP];
        ack_q  <= wdata_i[CB_ACK];
        flag_q <= flag_q & wdata_i[CB_FLAG];
      end
      if (!en_q) begin
        pend_q <= 1'b0;
      end else if (cmd_valid_o) begin
        pend_q <= 1'b1; cur_q <= cmd_o; rep_q <= bus_held_i;
        lat_q  <= data_q; acki_q <= ack_q;
      end
      if (can_go && sto_q && !bus_held_i) sto_q <= 1'b0;
      if (pend_q && done_i) begin
        pend_q <= 1'b0;
        if (arb_lost_i) begin
          stat_q <= ST_ARB; flag_q <= 1'b1;
        end else begin
          unique case (cur_q)
            CMD_START: begin
              stat_q <= rep_q ? ST_RSTART : ST_START;
              flag_q <= 1'b1; sta_q <= 1'b0; nx_q <= NX_ADDR;
            end
            CMD_STOP: begin
              stat_q <= ST_NONE; sto_q <= 1'b0;
            end
            CMD_WRITE: begin
              flag_q <= 1'b1;
              unique case (nx_q)
                NX_ADDR: begin
                  rw_q <= lat_q[0];
                  if (lat_q[0]) stat_q <= ack_seen_i ? ST_RA_ACK : ST_RA_NAK;
                  else          stat_q <= ack_seen_i ? ST_WA_ACK : ST_WA_NAK;
                  if (lat_q[7:3] == TEN_MARK) nx_q <= NX_ADDR2;
                  else                        nx_q <= lat_q[0] ? NX_RX : NX_TX;
                end
                NX_ADDR2: begin
                  if (rw_q) stat_q <= ack_seen_i ? ST_R2_ACK : ST_R2_NAK;
                  else      stat_q <= ack_seen_i ? ST_W2_ACK : ST_W2_NAK;
                  nx_q <= rw_q ? NX_RX : NX_TX;
                end
                default: stat_q <= ack_seen_i ? ST_WD_ACK : ST_WD_NAK;
              endcase
            end
            CMD_READ: begin
              flag_q <= 1'b1;
              data_q <= rx_byte_i;
              stat_q <= acki_q ? ST_RD_ACK : ST_RD_NAK;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_DATA: rdata_o = data_q;
      RA_CTRL: rdata_o = {ien_q, en_q, sta_q, sto_q, flag_q, ack_q, 2'b00};
      RA_STAT: rdata_o = stat_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = flag_q & ien_q;
  assign tx_byte_o = data_q;
  assign ack_out_o = ack_q;
  assign flag_o    = flag_q;
  assign status_o  = stat_q;
  assign en_o      = en_q;
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2c_sm_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = REG_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o
);
  logic          eng_idle, bus_held, done, arb_lost, ack_seen, cmd_valid, ack_out, clr;
  logic          flag_w, en_w;
  logic [DW-1:0] rx_byte, tx_byte, status_w;
  cmd_e          cmd;

  i2c_sm_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
    .eng_idle_i  (eng_idle),
    .bus_held_i  (bus_held),
    .done_i      (done),
    .arb_lost_i  (arb_lost),
    .ack_seen_i  (ack_seen),
    .rx_byte_i   (rx_byte),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .tx_byte_o   (tx_byte),
    .ack_out_o   (ack_out),
    .clr_o       (clr),
    .flag_o      (flag_w),
    .status_o    (status_w),
    .en_o        (en_w)
  );

  i2c_sm_bit_eng #(.BYTE_W(DW)) u_eng (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .tick_i,
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .tx_byte_i   (tx_byte),
    .ack_out_i   (ack_out),
    .sda_i,
    .done_o      (done),
    .arb_lost_o  (arb_lost),
    .ack_seen_o  (ack_seen),
    .rx_byte_o   (rx_byte),
    .idle_o      (eng_idle),
    .bus_held_o  (bus_held),
    .scl_low_o,
    .sda_low_o
  );
endmodule

// File: rtl/i2c_status_master_chk.sv
module i2c_status_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic       flag_i,
  input logic [7:0] status_i,
  input logic       en_i,
  input logic       scl_low_i,
  input logic       sda_low_i
);
  a_r7_scl_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && en_i && status_i != 8'h38) |-> scl_low_i);

  a_r10_arb_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && status_i == 8'h38) |-> (!scl_low_i && !sda_low_i));

  a_r11_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_low_i && !sda_low_i));

  a_r12_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd3) |=> (status_i == 8'hF8 && !flag_i && !en_i));

  a_r2_flag_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> status_i != 8'hF8);
endmodule

bind i2c_status_master i2c_status_master_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .flag_i    (flag_w),
  .status_i  (status_w),
  .en_i      (en_w),
  .scl_low_i (scl_low_o),
  .sda_low_i (sda_low_o)
);

// File: tb/test_i2c_status_master.sv
module test_i2c_status_master;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, slv_low = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       finished = 1'b0;
  wire  [7:0] rdata;
  wire        irq, scl_low, sda_low;
  wire        scl = !scl_low;
  wire        sda = !(sda_low | slv_low);
  int         n_chk = 0, n_err = 0, n_start = 0, n_stop = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tick <= ~tick;
  always @(negedge sda) if (scl) n_start++;
  always @(posedge sda) if (scl) n_stop++;

  i2c_status_master i_i2c_status_master (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sda_i(sda),
    .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_bit(input string req, input int b, input logic val);
    logic [7:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, v);
      if (v[b] == val) break;
    end
    check(req, {31'd0, v[b]}, {31'd0, val});
  endtask

  task automatic expect_stat(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(2'd2, v);
    check(req, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic slave_byte(input logic rdm, input logic [7:0] tx, input logic ack,
                            output logic [7:0] got, output logic mack);
    for (int i = 7; i >= 0; i--) begin
      slv_low = rdm ? ~tx[i] : 1'b0;
      @(posedge scl); got[i] = sda;
      @(negedge scl);
    end
    slv_low = rdm ? 1'b0 : ack;
    @(posedge scl); mack = !sda;
    @(negedge scl); slv_low = 1'b0;
  endtask

  // one byte: write mode sends d, read mode receives sdat; returns what crossed the bus
  task automatic xfer(input logic rdm, input logic [7:0] d, input logic sack, input logic ackb,
                      output logic [7:0] got, output logic mack);
    if (!rdm) wr(2'd0, d);
    fork
      slave_byte(rdm, d, sack, got, mack);
      wr(2'd1, 8'hC0 | (ackb ? 8'h04 : 8'h00));
    join
    wait_bit("R7 flag after byte", 3, 1'b1);
  endtask

  task automatic do_start(input string req, input logic [7:0] exp);
    wr(2'd1, 8'hE0);
    wait_bit(req, 3, 1'b1);
    expect_stat(req, exp);
  endtask

  task automatic do_stop();
    wr(2'd1, 8'hD0);
    wait_bit("R9 stop self-clears", 4, 1'b0);
    expect_stat("R9 status after stop", 8'hF8);
    check("R9 scl released", {31'd0, scl_low}, 32'd0);
    check("R9 sda released", {31'd0, sda_low}, 32'd0);
    check("R9 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    expect_stat("R1 reset status", 8'hF8);
    rd(2'd1, v); check("R1 reset control", {24'd0, v}, 32'd0);
    rd(2'd0, v); check("R1 reset data", {24'd0, v}, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R1 reset lines", {30'd0, scl_low, sda_low}, 32'd0);
  endtask

  task automatic t_write7();
    logic [7:0] g; logic m; logic [7:0] v; int s0, p0;
    s0 = n_start; p0 = n_stop;
    do_start("R2 start code", 8'h08);
    check("R2 start condition seen", n_start - s0, 32'd1);
    check("R8 irq with ien", {31'd0, irq}, 32'd1);
    repeat (12) @(negedge clk);
    check("R7 scl held while flag", {31'd0, scl_low}, 32'd1);
    wr(2'd1, 8'hC8);
    repeat (20) @(negedge clk);
    rd(2'd1, v); check("R7 flag kept by writing 1", {31'd0, v[3]}, 32'd1);
    expect_stat("R7 no action while flag", 8'h08);
    xfer(1'b0, 8'hA0, 1'b1, 1'b0, g, m);
    check("R3 address bits on bus", {24'd0, g}, 32'hA0);
    expect_stat("R3 write addr ack", 8'h18);
    xfer(1'b0, 8'h3C, 1'b1, 1'b0, g, m);
    check("R4 data bits on bus", {24'd0, g}, 32'h3C);
    expect_stat("R4 data ack", 8'h28);
    xfer(1'b0, 8'h81, 1'b0, 1'b0, g, m);
    expect_stat("R4 data nack", 8'h30);
    do_stop();
    check("R9 stop condition seen", n_stop - p0, 32'd1);
  endtask

  task automatic t_read7();
    logic [7:0] g; logic m; logic [7:0] v;
    do_start("R2 start code", 8'h08);
    xfer(1'b0, 8'hA1, 1'b1, 1'b0, g, m);
    expect_stat("R3 read addr ack", 8'h40);
    xfer(1'b1, 8'h5A, 1'b0, 1'b1, g, m);
    expect_stat("R5 read with ack", 8'h50);
    rd(2'd0, v); check("R5 received byte", {24'd0, v}, 32'h5A);
    check("R5 master drove ack", {31'd0, m}, 32'd1);
    xfer(1'b1, 8'hC3, 1'b0, 1'b0, g, m);
    expect_stat("R5 read with nack", 8'h58);
    rd(2'd0, v); check("R5 received last byte", {24'd0, v}, 32'hC3);
    check("R5 master left nack", {31'd0, m}, 32'd0);
    do_start("R2 repeated start code", 8'h10);
    xfer(1'b0, 8'hA0, 1'b0, 1'b0, g, m);
    expect_stat("R3 write addr nack", 8'h20);
    do_start("R2 repeated start code", 8'h10);
    xfer(1'b0, 8'hA1, 1'b0, 1'b0, g, m);
    expect_stat("R3 read addr nack", 8'h48);
    do_stop();
  endtask

  task automatic t_ten();
    logic [7:0] g; logic m; logic [7:0] v;
    do_start("R6 start", 8'h08);
    xfer(1'b0, 8'hF4, 1'b1, 1'b0, g, m);
    expect_stat("R6 first byte write ack", 8'h18);
    xfer(1'b0, 8'h5B, 1'b1, 1'b0, g, m);
    check("R6 second byte on bus", {24'd0, g}, 32'h5B);
    expect_stat("R6 write second ack", 8'hD0);
    xfer(1'b0, 8'h77, 1'b1, 1'b0, g, m);
    expect_stat("R6 data after second byte", 8'h28);
    do_start("R6 rstart", 8'h10);
    xfer(1'b0, 8'hF5, 1'b1, 1'b0, g, m);
    expect_stat("R6 first byte read ack", 8'h40);
    xfer(1'b0, 8'h5B, 1'b0, 1'b0, g, m);
    expect_stat("R6 read second nack", 8'hE8);
    do_start("R6 rstart", 8'h10);
    xfer(1'b0, 8'hF5, 1'b1, 1'b0, g, m);
    xfer(1'b0, 8'h5B, 1'b1, 1'b0, g, m);
    expect_stat("R6 read second ack", 8'hE0);
    xfer(1'b1, 8'h96, 1'b0, 1'b0, g, m);
    expect_stat("R6 read path after second", 8'h58);
    rd(2'd0, v); check("R6 read byte", {24'd0, v}, 32'h96);
    do_start("R6 rstart", 8'h10);
    xfer(1'b0, 8'hF4, 1'b1, 1'b0, g, m);
    xfer(1'b0, 8'h5B, 1'b0, 1'b0, g, m);
    expect_stat("R6 write second nack", 8'hD8);
    do_stop();
  endtask

  task automatic t_arb();
    do_start("R10 start", 8'h08);
    wr(2'd0, 8'hFF);
    slv_low = 1'b1;
    wr(2'd1, 8'hC0);
    wait_bit("R10 flag on loss", 3, 1'b1);
    expect_stat("R10 lost code", 8'h38);
    check("R10 lines released", {30'd0, scl_low, sda_low}, 32'd0);
    check("R10 irq", {31'd0, irq}, 32'd1);
    slv_low = 1'b0;
    repeat (4) @(negedge clk);
    do_start("R10 fresh start after loss", 8'h08);
    do_stop();
  endtask

  task automatic t_noirq();
    wr(2'd1, 8'h60);
    wait_bit("R8 flag without ien", 3, 1'b1);
    repeat (4) @(negedge clk);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd1, 8'h50);
    wait_bit("R9 stop without ien", 4, 1'b0);
    check("R8 irq stays low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_disable();
    logic [7:0] v; int s0;
    s0 = n_start;
    wr(2'd1, 8'h20);
    repeat (60) @(negedge clk);
    rd(2'd1, v); check("R11 no flag when disabled", {31'd0, v[3]}, 32'd0);
    expect_stat("R11 status unchanged", 8'hF8);
    check("R11 lines released", {30'd0, scl_low, sda_low}, 32'd0);
    check("R11 no start seen", n_start - s0, 32'd0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_srst();
    logic [7:0] v;
    do_start("R12 start", 8'h08);
    wr(2'd0, 8'h55);
    wr(2'd3, 8'h00);
    rd(2'd1, v); check("R12 control cleared", {24'd0, v}, 32'd0);
    rd(2'd0, v); check("R12 data cleared", {24'd0, v}, 32'd0);
    expect_stat("R12 status reset", 8'hF8);
    repeat (4) @(negedge clk);
    check("R12 bus released", {30'd0, scl_low, sda_low}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write7();
    t_read7();
    t_ten();
    t_arb();
    t_noirq();
    t_disable();
    t_srst();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule